// File: doc/BRIEF.md
# Prefixed Move-Instruction Decoder

This block takes 16-bit move-style instruction words and splits each one into a source descriptor and a destination descriptor. The top bit chooses the source form. In immediate form the low byte is an 8-bit literal. In register form the low byte names a module in its low nibble and one of sixteen registers in its high nibble. The destination is always a register. Its module comes from bits 11:8, and bits 14:12 give a 3-bit subindex within that module.

Only the first eight registers of a module can be reached as a destination in a single word. A prefix register, which sits at a fixed destination address, widens this reach. An immediate write to that address produces no decoded output. It stores two extra index bits, and those bits form the upper part of the 5-bit destination index of the next accepted word only. This means an extended-destination move occupies two word slots.

Top module: `mvdec_top`

## Requirements
- R1: `out_is_reg` carries bit 15 of the accepted word: 0 means an immediate source and 1 means a register source.
- R2: For an immediate-source word, `out_imm` equals bits 7:0, and `out_src_mod` and `out_src_idx` are 0.
- R3: For a register-source word, `out_src_mod` equals bits 3:0, `out_src_idx` equals bits 7:4, and `out_imm` is 0.
- R4: `out_dst_mod` equals bits 11:8. `out_dst_idx` is 5 bits wide: its low 3 bits are bits 14:12 and its upper 2 bits are the pending prefix value, which is 0 when nothing is pending.
- R5: A prefix write is an immediate-source word whose destination module is 11 and whose full 5-bit destination index is 0. It raises no `out_valid`, and it sets the pending prefix to bits 1:0 of the immediate.
- R6: A register-source word aimed at the prefix address is decoded as an ordinary move, with `out_valid`, and it does not arm a prefix.
- R7: A pending prefix is used by exactly the next accepted word and then returns to 0. Cycles with `in_valid` low leave it unchanged.
- R8: `out_valid` pulses in the cycle after each accepted word that is not a prefix write. When there is no such word, the descriptor outputs keep their last values.
- R9: A synchronous reset sets `out_valid`, every descriptor output and the pending prefix to 0.
- R10: When a nonzero prefix is pending, a word aimed at module 11, subindex 0 is an ordinary move to the extended index {prefix, 000}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies `in_word` in this cycle |
| in_word | input | 16 | Instruction word |
| out_valid | output | 1 | One-cycle pulse when a decoded descriptor is presented |
| out_is_reg | output | 1 | Source form: 1 for register, 0 for immediate |
| out_imm | output | 8 | Immediate source value |
| out_src_mod | output | 4 | Source module |
| out_src_idx | output | 4 | Source register index |
| out_dst_mod | output | 4 | Destination module |
| out_dst_idx | output | 5 | Full destination index, including the prefix bits |

## Verification
Consuming a pending prefix and arming a new one can happen on the same word. This occurs when a prefix write of value 0 is followed by another prefix write: the word clears the old prefix and stores a new one in the same edge. The bench forces this case directly and also produces it through a random stream that is weighted toward prefix writes and idle gaps. A behavioural model checks on every clock that the next accepted word picks up the new prefix and no stale one. The same every-clock comparison also covers a reset that arrives while a prefix is pending.

// File: rtl/mvdec_pkg.sv
package mvdec_pkg;
  typedef enum logic {
    SRC_IMM = 1'b0,
    SRC_REG = 1'b1
  } src_kind_e;
endpackage

// File: rtl/mvdec_field_split.sv
module mvdec_field_split #(
  parameter int IMM_W  = 8,
  parameter int MOD_W  = 4,
  parameter int DSUB_W = 3,
  localparam int SIDX_W = IMM_W - MOD_W,
  localparam int WORD_W = 1 + DSUB_W + MOD_W + IMM_W
) (
  input  logic [WORD_W-1:0] word,
  output mvdec_pkg::src_kind_e kind,
  output logic [IMM_W-1:0]  imm,
  output logic [MOD_W-1:0]  src_mod,
  output logic [SIDX_W-1:0] src_idx,
  output logic [MOD_W-1:0]  dst_mod,
  output logic [DSUB_W-1:0] dst_sub
);
  logic [IMM_W-1:0] low_field;

  always_comb begin
    low_field = word[IMM_W-1:0];
    kind      = mvdec_pkg::src_kind_e'(word[WORD_W-1]);
    dst_mod   = word[IMM_W +: MOD_W];
    dst_sub   = word[IMM_W+MOD_W +: DSUB_W];
    if (kind == mvdec_pkg::SRC_REG) begin
      imm     = '0;
      src_mod = low_field[MOD_W-1:0];
      src_idx = low_field[IMM_W-1:MOD_W];
    end else begin
      imm     = low_field;
      src_mod = '0;
      src_idx = '0;
    end
  end
endmodule

// File: rtl/mvdec_prefix.sv
module mvdec_prefix #(
  parameter int IMM_W   = 8,
  parameter int MOD_W   = 4,
  parameter int DSUB_W  = 3,
  parameter int PFX_W   = 2,
  parameter int PFX_MOD = 11,
  parameter int PFX_IDX = 0,
  localparam int DIDX_W = DSUB_W + PFX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  mvdec_pkg::src_kind_e kind,
  input  logic [IMM_W-1:0]  imm,
  input  logic [MOD_W-1:0]  dst_mod,
  input  logic [DSUB_W-1:0] dst_sub,
  output logic [PFX_W-1:0]  pfx_q,
  output logic [DIDX_W-1:0] full_idx,
  output logic              pfx_hit
);
  always_comb begin
    full_idx = {pfx_q, dst_sub};
    pfx_hit  = (kind == mvdec_pkg::SRC_IMM) &&
               (dst_mod == MOD_W'(PFX_MOD)) &&
               (full_idx == DIDX_W'(PFX_IDX));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pfx_q <= '0;
    end else if (accept) begin
      if (pfx_hit) pfx_q <= imm[PFX_W-1:0];
      else         pfx_q <= '0;
    end
  end
endmodule

// File: rtl/mvdec_outreg.sv
module mvdec_outreg #(
  parameter int IMM_W  = 8,
  parameter int MOD_W  = 4,
  parameter int SIDX_W = 4,
  parameter int DIDX_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              is_reg,
  input  logic [IMM_W-1:0]  imm,
  input  logic [MOD_W-1:0]  src_mod,
  input  logic [SIDX_W-1:0] src_idx,
  input  logic [MOD_W-1:0]  dst_mod,
  input  logic [DIDX_W-1:0] dst_idx,
  output logic              v_q,
  output logic              is_reg_q,
  output logic [IMM_W-1:0]  imm_q,
  output logic [MOD_W-1:0]  src_mod_q,
  output logic [SIDX_W-1:0] src_idx_q,
  output logic [MOD_W-1:0]  dst_mod_q,
  output logic [DIDX_W-1:0] dst_idx_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      v_q       <= 1'b0;
      is_reg_q  <= 1'b0;
      imm_q     <= '0;
      src_mod_q <= '0;
      src_idx_q <= '0;
      dst_mod_q <= '0;
      dst_idx_q <= '0;
    end else begin
      v_q <= load;
      if (load) begin
        is_reg_q  <= is_reg;
        imm_q     <= imm;
        src_mod_q <= src_mod;
        src_idx_q <= src_idx;
        dst_mod_q <= dst_mod;
        dst_idx_q <= dst_idx;
      end
    end
  end
endmodule

// File: rtl/mvdec_top.sv
module mvdec_top #(
  parameter int IMM_W   = 8,
  parameter int MOD_W   = 4,
  parameter int DSUB_W  = 3,
  parameter int PFX_W   = 2,
  parameter int PFX_MOD = 11,
  parameter int PFX_IDX = 0,
  localparam int SIDX_W = IMM_W - MOD_W,
  localparam int DIDX_W = DSUB_W + PFX_W,
  localparam int WORD_W = 1 + DSUB_W + MOD_W + IMM_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  output logic              out_valid,
  output logic              out_is_reg,
  output logic [IMM_W-1:0]  out_imm,
  output logic [MOD_W-1:0]  out_src_mod,
  output logic [SIDX_W-1:0] out_src_idx,
  output logic [MOD_W-1:0]  out_dst_mod,
  output logic [DIDX_W-1:0] out_dst_idx
);
  mvdec_pkg::src_kind_e kind;
  logic [IMM_W-1:0]  imm;
  logic [MOD_W-1:0]  src_mod;
  logic [SIDX_W-1:0] src_idx;
  logic [MOD_W-1:0]  dst_mod;
  logic [DSUB_W-1:0] dst_sub;
  logic [PFX_W-1:0]  pfx_q;
  logic [DIDX_W-1:0] full_idx;
  logic              pfx_hit;
  logic              load;

  mvdec_field_split #(.IMM_W(IMM_W), .MOD_W(MOD_W), .DSUB_W(DSUB_W)) split_i (
    .word(in_word), .kind(kind), .imm(imm), .src_mod(src_mod),
    .src_idx(src_idx), .dst_mod(dst_mod), .dst_sub(dst_sub)
  );

  mvdec_prefix #(
    .IMM_W(IMM_W), .MOD_W(MOD_W), .DSUB_W(DSUB_W), .PFX_W(PFX_W),
    .PFX_MOD(PFX_MOD), .PFX_IDX(PFX_IDX)
  ) pfx_i (
    .clk(clk), .rst(rst), .accept(in_valid), .kind(kind), .imm(imm),
    .dst_mod(dst_mod), .dst_sub(dst_sub), .pfx_q(pfx_q),
    .full_idx(full_idx), .pfx_hit(pfx_hit)
  );

  assign load = in_valid && !pfx_hit;

  mvdec_outreg #(.IMM_W(IMM_W), .MOD_W(MOD_W), .SIDX_W(SIDX_W), .DIDX_W(DIDX_W)) out_i (
    .clk(clk), .rst(rst), .load(load), .is_reg(kind == mvdec_pkg::SRC_REG),
    .imm(imm), .src_mod(src_mod), .src_idx(src_idx), .dst_mod(dst_mod),
    .dst_idx(full_idx), .v_q(out_valid), .is_reg_q(out_is_reg),
    .imm_q(out_imm), .src_mod_q(out_src_mod), .src_idx_q(out_src_idx),
    .dst_mod_q(out_dst_mod), .dst_idx_q(out_dst_idx)
  );
endmodule

// File: rtl/mvdec_chk.sv
module mvdec_chk #(
  parameter int IMM_W   = 8,
  parameter int MOD_W   = 4,
  parameter int DSUB_W  = 3,
  parameter int PFX_W   = 2,
  parameter int PFX_MOD = 11,
  parameter int PFX_IDX = 0,
  localparam int SIDX_W = IMM_W - MOD_W,
  localparam int DIDX_W = DSUB_W + PFX_W,
  localparam int WORD_W = 1 + DSUB_W + MOD_W + IMM_W
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [WORD_W-1:0] in_word,
  input logic              out_valid,
  input logic              out_is_reg,
  input logic [IMM_W-1:0]  out_imm,
  input logic [MOD_W-1:0]  out_src_mod,
  input logic [SIDX_W-1:0] out_src_idx,
  input logic [MOD_W-1:0]  out_dst_mod,
  input logic [DIDX_W-1:0] out_dst_idx,
  input logic [PFX_W-1:0]  pfx_q
);
  logic word_is_pfx;
  assign word_is_pfx = !in_word[WORD_W-1] &&
                       (in_word[IMM_W +: MOD_W] == MOD_W'(PFX_MOD)) &&
                       ({pfx_q, in_word[IMM_W+MOD_W +: DSUB_W]} == DIDX_W'(PFX_IDX));

  assert_pfx_silent_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && word_is_pfx) |=> !out_valid);

  assert_pfx_arm_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && word_is_pfx) |=> (pfx_q == $past(in_word[PFX_W-1:0])));

  assert_decode_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !word_is_pfx) |=> out_valid);

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(out_dst_idx) && $stable(out_imm)));

  assert_pfx_once_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !word_is_pfx) |=> (pfx_q == '0));

  assert_pfx_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(pfx_q));

  assert_imm_src_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_is_reg) |-> (out_src_mod == '0 && out_src_idx == '0));

  assert_reg_imm_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_is_reg) |-> (out_imm == '0));

  assert_dst_upper_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !word_is_pfx) |=> (out_dst_idx[DIDX_W-1:DSUB_W] == $past(pfx_q)));
endmodule

bind mvdec_top mvdec_chk #(
  .IMM_W(IMM_W), .MOD_W(MOD_W), .DSUB_W(DSUB_W), .PFX_W(PFX_W),
  .PFX_MOD(PFX_MOD), .PFX_IDX(PFX_IDX)
) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
  .out_valid(out_valid), .out_is_reg(out_is_reg), .out_imm(out_imm),
  .out_src_mod(out_src_mod), .out_src_idx(out_src_idx),
  .out_dst_mod(out_dst_mod), .out_dst_idx(out_dst_idx), .pfx_q(pfx_q)
);

// File: tb/mvdec_top_tb_top.sv
module mvdec_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] in_word = '0;
  logic        out_valid, out_is_reg;
  logic [7:0]  out_imm;
  logic [3:0]  out_src_mod, out_src_idx, out_dst_mod;
  logic [4:0]  out_dst_idx;

  int n_chk = 0;
  int n_bad = 0;
  int ref_pfx = 0;
  int e_v = 0, e_reg = 0, e_imm = 0, e_smod = 0, e_sidx = 0, e_dmod = 0, e_didx = 0;
  int cycles = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  mvdec_top dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
    .out_valid(out_valid), .out_is_reg(out_is_reg), .out_imm(out_imm),
    .out_src_mod(out_src_mod), .out_src_idx(out_src_idx),
    .out_dst_mod(out_dst_mod), .out_dst_idx(out_dst_idx)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Compares every output against the model; called between edges.
  task automatic compare_all();
    chk("R8", "out_valid", int'(out_valid), e_v);
    chk("R1", "out_is_reg", int'(out_is_reg), e_reg);
    chk("R2", "out_imm", int'(out_imm), e_imm);
    chk("R3", "out_src_mod", int'(out_src_mod), e_smod);
    chk("R3", "out_src_idx", int'(out_src_idx), e_sidx);
    chk("R4", "out_dst_mod", int'(out_dst_mod), e_dmod);
    chk("R4", "out_dst_idx", int'(out_dst_idx), e_didx);
  endtask

  // Drive one cycle at the falling edge, update the model, then check after the next edge.
  task automatic step(input logic r, input logic v, input logic [15:0] w);
    bit is_pfx;
    int didx;
    @(negedge clk);
    rst = r; in_valid = v; in_word = w;
    didx = (ref_pfx << 3) | int'(w[14:12]);
    is_pfx = !w[15] && (w[11:8] == 4'd11) && (didx == 0);
    if (r) begin
      ref_pfx = 0;
      e_v = 0; e_reg = 0; e_imm = 0; e_smod = 0; e_sidx = 0; e_dmod = 0; e_didx = 0;
    end else if (v) begin
      if (is_pfx) begin
        e_v = 0;
        ref_pfx = int'(w[1:0]);
      end else begin
        e_v = 1;
        e_reg = int'(w[15]);
        e_imm = w[15] ? 0 : int'(w[7:0]);
        e_smod = w[15] ? int'(w[3:0]) : 0;
        e_sidx = w[15] ? int'(w[7:4]) : 0;
        e_dmod = int'(w[11:8]);
        e_didx = didx;
        ref_pfx = 0;
      end
    end else begin
      e_v = 0;
    end
    @(posedge clk);
    #1;
    compare_all();
  endtask

  function automatic logic [15:0] mk(input bit f, input int sub, input int dmod, input int lo);
    return {f, 3'(sub), 4'(dmod), 8'(lo)};
  endfunction

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
      end
    end
  end

  initial begin
    step(1, 0, 16'h0); step(1, 0, 16'h0);
    // R9: reset state
    step(0, 0, 16'h0);
    // R2: immediate move
    step(0, 1, mk(0, 5, 3, 8'hA7));
    // R3, R1: register move
    step(0, 1, mk(1, 2, 7, 8'h9C));
    // R8: idle cycle holds fields
    step(0, 0, 16'hFFFF);
    // R5: prefix write of 2, then R4/R7 extended destination
    step(0, 1, mk(0, 0, 11, 2));
    chk("R5", "no pulse on prefix", int'(out_valid), 0);
    step(0, 1, mk(0, 5, 4, 8'h11));
    chk("R4", "extended index", int'(out_dst_idx), 21);
    step(0, 1, mk(0, 5, 4, 8'h12));
    chk("R7", "prefix cleared", int'(out_dst_idx), 5);
    // R7: prefix survives idle gaps
    step(0, 1, mk(0, 0, 11, 3));
    step(0, 0, 16'h0); step(0, 0, 16'h0); step(0, 0, 16'h0);
    step(0, 1, mk(1, 6, 2, 8'h34));
    chk("R7", "prefix after idle", int'(out_dst_idx), 30);
    // R6: register source to prefix address is an ordinary move
    step(0, 1, mk(1, 0, 11, 8'h21));
    chk("R6", "reg write decoded", int'(out_valid), 1);
    step(0, 1, mk(0, 1, 1, 0));
    chk("R6", "no prefix armed", int'(out_dst_idx), 1);
    // R10: nonzero prefix turns the prefix address into an extended destination
    step(0, 1, mk(0, 0, 11, 1));
    step(0, 1, mk(0, 0, 11, 8'h55));
    chk("R10", "extended ordinary move", int'(out_valid), 1);
    chk("R10", "extended index 8", int'(out_dst_idx), 8);
    // Overlap: zero prefix consumed while a new prefix is armed
    step(0, 1, mk(0, 0, 11, 0));
    step(0, 1, mk(0, 0, 11, 3));
    chk("R5", "re-armed silently", int'(out_valid), 0);
    step(0, 1, mk(0, 7, 9, 0));
    chk("R7", "new prefix used", int'(out_dst_idx), 31);
    // R9: reset while a prefix is pending
    step(0, 1, mk(0, 0, 11, 2));
    step(1, 0, 16'h0);
    step(0, 1, mk(0, 3, 6, 8'h44));
    chk("R9", "prefix cleared by reset", int'(out_dst_idx), 3);
    // Weighted random stream
    for (int i = 0; i < 3000; i++) begin
      int sel;
      logic [15:0] w;
      sel = $urandom_range(0, 9);
      w = 16'($urandom);
      if (sel < 3) w = mk(0, 0, 11, int'(w[7:0]));
      step(0, sel != 9, w);
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule